// File: doc/BRIEF.md
# UART Receive Holding Queue with Fill-Level Interrupt

This block sits between a UART receive shift register and the software that consumes received bytes. Each time the shift register completes a character, it presents the byte with a one-cycle completion strobe. The block stores the byte in a four-entry first-in first-out queue. The oldest stored byte is always shown on the read-data output. A one-cycle read strobe removes that byte.

A two-bit select chooses when the block pulses its interrupt output:
- on every stored character;
- on the transfer that brings the queue to three characters;
- on the transfer that brings the queue to four characters.

If a character completes while the queue is already full, the block raises a sticky overrun flag and drops the character. While the flag is up, no further characters are accepted. A software clear pulse lowers the flag and also discards everything held in the queue. A receiver-idle output reports, one cycle late, whether the shift register is in the middle of a frame.

Top module: `uart_rx_holding`

## Requirements
- R1: The queue holds up to 4 bytes. `rd_data` always shows the oldest stored byte. A `rd_pop` pulse while data is available removes that byte, so bytes leave in the order they were stored.
- R2: `data_avail` is 1 exactly when at least one byte is stored. It is 0 after reset.
- R3: With `isel` = 2'b11, `irq` is high for one cycle, in the cycle after the clock edge whose store leaves exactly 4 bytes in the queue. It is low after every other edge.
- R4: With `isel` = 2'b10, `irq` pulses for one cycle after the edge whose store leaves exactly 3 bytes in the queue. It is low otherwise.
- R5: With `isel` = 2'b00 or 2'b01, `irq` pulses for one cycle after every edge at which a byte is stored. A `char_done` that stores nothing gives no pulse.
- R6: Suppose `char_done` arrives while the queue holds 4 bytes and `ovf_flag` is 0. Then `ovf_flag` becomes 1 after that edge, the byte is dropped and the stored bytes are unchanged. Fullness is judged before any `rd_pop` in the same cycle.
- R7: While `ovf_flag` is 1, `char_done` stores nothing and raises no interrupt. `rd_pop` still removes bytes.
- R8: An `ovf_clear` pulse clears `ovf_flag` and empties the queue after that edge. A `char_done` or `rd_pop` in the same cycle is ignored.
- R9: A `rd_pop` while the queue is empty has no effect.
- R10: `rx_idle` is 1 after reset. After each edge it equals the inverse of `frame_active` sampled at that edge.
- R11: A store and a pop in the same cycle both take effect when the queue is not full. The threshold test of R3 and R4 uses the count after both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_done | input | 1 | One-cycle strobe: a character has completed |
| char_byte | input | 8 | Byte of the completed character |
| rd_pop | input | 1 | One-cycle read strobe; removes the oldest byte |
| ovf_clear | input | 1 | Software clear of the overrun flag; also empties the queue |
| isel | input | 2 | Interrupt threshold select (11: full, 10: three, 0x: every byte) |
| frame_active | input | 1 | Shift register is receiving a frame |
| rd_data | output | 8 | Oldest stored byte |
| data_avail | output | 1 | At least one byte stored |
| ovf_flag | output | 1 | Sticky overrun flag |
| rx_idle | output | 1 | Receiver idle, registered |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench pairs the threshold modes with a store and a pop in the same cycle. A design that tested the count before the pop would miss the three-byte interrupt in mode 10 when a store and a pop land together at three bytes held. The bench fills the queue and keeps sending characters, with and without a simultaneous pop. A design that let a byte in on the full edge, or judged fullness after the pop, would show a wrong head byte or a missing overrun. The bench also sends characters while the flag is up, and fires a clear in the same cycle as a character. Either mistake there, storing during overrun or letting a byte survive the clear, shows as a `data_avail` or interrupt mismatch. Long random runs over all four select values complete the comparison against a queue-based model.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
    // interrupt threshold select encodings
    localparam logic [1:0] ISEL_FULL  = 2'b11;
    localparam logic [1:0] ISEL_THREE = 2'b10;
endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PW-1:0]               wr;
        logic [PW-1:0]               rd;
        logic [CW-1:0]               cnt;
    } store_t;

    store_t st_d, st_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.cnt = '0;
        end else begin
            if (push) begin
                st_d.mem[st_q.wr] = din;
                st_d.wr           = bump(st_q.wr);
            end
            if (pop) begin
                st_d.rd = bump(st_q.rd);
            end
            st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout  = st_q.mem[st_q.rd];
    assign count = st_q.cnt;

    // R1: occupancy never passes the capacity
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    // R1: the controller never writes into a full queue
    a_r1_push_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> st_q.cnt != CW'(DEPTH));
    // R9: the controller never pops an empty queue
    a_r9_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> st_q.cnt != '0);
endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int THREE_Q = (DEPTH * 3) / 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          char_done,
    input  logic          rd_pop,
    input  logic          ovf_clear,
    input  logic [1:0]    isel,
    input  logic          frame_active,
    input  logic [CW-1:0] count,
    output logic          push,
    output logic          pop,
    output logic          flush,
    output logic          ovf_flag,
    output logic          irq,
    output logic          rx_idle
);
    typedef struct packed {
        logic ovf;
        logic irq;
        logic idle;
    } ctl_t;

    ctl_t cs_d, cs_q;
    logic          full;
    logic          hit;
    logic [CW:0]   after;

    always_comb begin
        full  = (count == CW'(DEPTH));
        flush = ovf_clear;
        push  = !ovf_clear && char_done && !cs_q.ovf && !full;
        pop   = !ovf_clear && rd_pop && (count != '0);
        after = {1'b0, count} + (CW+1)'(push) - (CW+1)'(pop);
        case (isel)
            ISEL_FULL:  hit = (after == (CW+1)'(DEPTH));
            ISEL_THREE: hit = (after == (CW+1)'(THREE_Q));
            default:    hit = 1'b1;
        endcase

        cs_d      = cs_q;
        cs_d.idle = !frame_active;
        cs_d.irq  = push && hit;
        if (ovf_clear) begin
            cs_d.ovf = 1'b0;
        end else if (char_done && !cs_q.ovf && full) begin
            cs_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '{ovf: 1'b0, irq: 1'b0, idle: 1'b1};
        end else begin
            cs_q <= cs_d;
        end
    end

    assign ovf_flag = cs_q.ovf;
    assign irq      = cs_q.irq;
    assign rx_idle  = cs_q.idle;

    // R6: overrun only rises from a character arriving at a full queue
    a_r6_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(char_done) && $past(count) == CW'(DEPTH)));
    // R7: nothing is stored while the flag stands
    a_r7_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clear) |-> !push);
    // R8: a clear leaves the flag down and the queue empty
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clear |=> (!ovf_flag && count == '0));
    // R5: every interrupt follows a character strobe
    a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(char_done));
    // R3: in full mode an interrupt means the queue is full
    a_r3_full_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(isel) == ISEL_FULL) |-> count == CW'(DEPTH));
    // R10: an active frame shows as not idle one cycle later
    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        frame_active |=> !rx_idle);
endmodule

// File: rtl/uart_rx_holding.sv
module uart_rx_holding #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             char_done,
    input  logic [WIDTH-1:0] char_byte,
    input  logic             rd_pop,
    input  logic             ovf_clear,
    input  logic [1:0]       isel,
    input  logic             frame_active,
    output logic [WIDTH-1:0] rd_data,
    output logic             data_avail,
    output logic             ovf_flag,
    output logic             rx_idle,
    output logic             irq
);
    logic          push, pop, flush;
    logic [CW-1:0] count;

    uart_rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .char_done    (char_done),
        .rd_pop       (rd_pop),
        .ovf_clear    (ovf_clear),
        .isel         (isel),
        .frame_active (frame_active),
        .count        (count),
        .push         (push),
        .pop          (pop),
        .flush        (flush),
        .ovf_flag     (ovf_flag),
        .irq          (irq),
        .rx_idle      (rx_idle)
    );

    uart_rxq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .flush (flush),
        .din   (char_byte),
        .dout  (rd_data),
        .count (count)
    );

    assign data_avail = (count != '0);

    // R2: data_avail drops only through a pop of the last byte or a clear
    a_r2_avail_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_avail) |-> ($past(rd_pop) || $past(ovf_clear)));
endmodule

// File: tb/sim_uart_rx_holding.sv
module sim_uart_rx_holding;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       char_done = 1'b0;
    logic [7:0] char_byte = 8'h00;
    logic       rd_pop = 1'b0;
    logic       ovf_clear = 1'b0;
    logic [1:0] isel = 2'b00;
    logic       frame_active = 1'b0;
    logic [7:0] rd_data;
    logic       data_avail, ovf_flag, rx_idle, irq;

    always #10 clk = ~clk;  // 50 MHz

    uart_rx_holding u0 (
        .clk(clk), .rst_n(rst_n), .char_done(char_done), .char_byte(char_byte),
        .rd_pop(rd_pop), .ovf_clear(ovf_clear), .isel(isel),
        .frame_active(frame_active), .rd_data(rd_data), .data_avail(data_avail),
        .ovf_flag(ovf_flag), .rx_idle(rx_idle), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] mq[$];
    bit m_ovf = 0, m_irq = 0, m_idle = 1;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string irq_tag(input logic [1:0] m);
        if (m == 2'b11) return "R3";
        if (m == 2'b10) return "R4";
        return "R5";
    endfunction

    // one clock: drive at negedge, update model, compare at next negedge
    task automatic step(input bit d, input logic [7:0] b, input bit p,
                        input bit c, input bit fa);
        int sz;
        bit st;
        char_done = d; char_byte = b; rd_pop = p; ovf_clear = c; frame_active = fa;
        sz = mq.size();
        m_idle = !fa;
        if (c) begin
            mq.delete(); m_ovf = 0; m_irq = 0;       // R8
        end else begin
            st = d && !m_ovf && sz < 4;
            if (d && !m_ovf && sz == 4) m_ovf = 1;    // R6
            if (p && sz > 0) void'(mq.pop_front());   // R9 when empty
            if (st) mq.push_back(b);
            m_irq = st && (!isel[1] || (isel == 2'b10 && mq.size() == 3) ||
                           (isel == 2'b11 && mq.size() == 4));   // R11
        end
        @(posedge clk);
        @(negedge clk);
        char_done = 0; rd_pop = 0; ovf_clear = 0;
        check("R2", data_avail, mq.size() > 0);
        check("R6", ovf_flag, m_ovf);
        check(irq_tag(isel), irq, m_irq);
        check("R10", rx_idle, m_idle);
        if (mq.size() > 0) check("R1", rd_data, mq[0]);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check("R2", data_avail, 0);
        check("R10", rx_idle, 1);
        check("R6", ovf_flag, 0);
        check("R5", irq, 0);
        rst_n = 1;
        @(negedge clk);

        // R5: every store interrupts; R9: pop on empty
        isel = 2'b00;
        step(1, 8'hA1, 0, 0, 1);
        step(1, 8'hB2, 0, 0, 1);
        isel = 2'b01;
        step(1, 8'hC3, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);   // R9
        // R4: three-byte threshold
        isel = 2'b10;
        for (int i = 0; i < 4; i++) step(1, 8'h10 + 8'(i), 0, 0, 0);
        // R6 full + char + pop: overrun, byte dropped
        step(1, 8'hEE, 1, 0, 0);
        // R7: ignored while flagged, pop still works
        step(1, 8'hEF, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        // R8: clear with simultaneous char
        step(1, 8'h55, 1, 1, 0);
        step(1, 8'h56, 0, 0, 0);
        // R11: mode 10, push+pop at three bytes keeps three and interrupts
        step(1, 8'h57, 0, 0, 0);
        step(1, 8'h58, 0, 0, 0);
        step(1, 8'h59, 1, 0, 0);
        // R3: full mode
        isel = 2'b11;
        step(1, 8'h5A, 0, 0, 0);
        step(1, 8'h5B, 0, 0, 0);   // R6 overrun at full
        step(0, 0, 0, 1, 0);       // R8
        for (int i = 0; i < 5; i++) step(1, 8'h70 + 8'(i), 0, 0, 0);
        step(0, 0, 0, 1, 0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            if (i % 200 == 0) isel = 2'($urandom_range(0, 3));
            step(($urandom % 3) != 0, 8'($urandom), ($urandom % 3) == 0,
                 ($urandom % 40) == 0, ($urandom % 2) == 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule